// File: doc/BRIEF.md
# Prioritized Interrupt Level Dispatcher

This block keeps the pending and enable state of a set of interrupt lines. It looks at each cycle's current status word and decides whether an interrupt entry has to happen. Every line has a fixed priority level and a fixed trigger type, both given by parameters:
- software bits change only through set and clear writes;
- edge bits latch on a rising input;
- level bits follow their input line.

The block finds the highest level that has a pending and enabled bit. It compares that level with the current interrupt level of the core. When the interrupt may be taken, it presents one registered entry record. For levels above 1, the record holds a direct per-level vector, the saved PC and saved status together with the slot they go to, and the new status word. For level 1, the entry is turned into a general exception: the record carries a fixed cause code and a kernel, user or double vector.

A wait-for-interrupt request first loads a new interrupt level into the status word. If nothing can be taken at that point, the block raises a halted flag. The flag stays up until an interrupt becomes takeable, and it drops in the same cycle as that entry strobe. The core is expected to apply the status update before the cycle after the next one. For this reason the block never takes two entries in consecutive cycles.

Top module: `irq_dispatch`

## Requirements
- R1: While reset is high, and in the first cycle after it, the pending register, the take strobe, the halted flag and every write-enable output are zero.
- R2: A software set write ORs its data into the pending register only at bit positions of software type (`SW_MASK`). Bits of other types are unchanged.
- R3: A software clear write clears only software and edge bits. A level-type bit always equals its input line as sampled at the previous clock edge, whatever is written.
- R4: An edge-type bit becomes pending when its input is 1 at an edge after being 0 at the edge before. It stays pending while the line is held high, until a clear write removes it.
- R5: An entry is taken only when three conditions all hold: the pending level is above the current level, the pending level is no greater than `NUM_LVL`, and some bit of that level is both pending and enabled. The status word layout is: interrupt level in bits [LW-1:0], exception-mode bit at LW, user-mode bit at LW+1. The current level is the larger of the level field and `EXCM_LEVEL`, where `EXCM_LEVEL` counts only while the exception-mode bit is set.
- R6: The pending level is the highest level with any pending and enabled bit. If that level exceeds `NUM_LVL`, nothing is taken, even when lower levels are ready.
- R7: Entry at a level L above 1 has the following effects:
  - it writes the PC to saved slot L and the prior status to the saved-status slot;
  - it writes status with level field L and exception mode set, keeping the user-mode bit;
  - it targets `VEC_BASE + L*VEC_STRIDE`;
  - it raises no exception request.
- R8: Entry at level 1 has the following effects:
  - it raises the exception request with cause `L1_CAUSE` and sets exception mode in the status written;
  - its vector is the double vector when exception mode was already set, otherwise the user vector when the user bit is set, otherwise the kernel vector;
  - the PC goes to slot 0 for a double entry when `HAS_DEPC` is set, otherwise to slot 1.
- R9: A wait request replaces the level field with its operand before the entry decision is made, and writes that status back. If no entry is taken in that cycle, the halted flag is set.
- R10: The halted flag clears in exactly the cycle in which the take strobe rises.
- R11: The take strobe is never high in two consecutive cycles.
- R12: Every output reflects the inputs and state of the preceding cycle through exactly one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | N | Interrupt input lines |
| set_we_i | input | 1 | Software set write strobe |
| set_data_i | input | N | Bits to set |
| clr_we_i | input | 1 | Software clear write strobe |
| clr_data_i | input | N | Bits to clear |
| en_we_i | input | 1 | Enable register write strobe |
| en_data_i | input | N | New enable value |
| status_i | input | LW+2 | Current status word |
| pc_i | input | XLEN | Current PC |
| wait_req_i | input | 1 | Wait-for-interrupt request |
| wait_lvl_i | input | LW | Level loaded by the wait request |
| pend_o | output | N | Pending register |
| take_o | output | 1 | Entry taken strobe |
| vector_o | output | XLEN | Entry target address |
| epc_we_o | output | 1 | Saved-PC write enable |
| epc_idx_o | output | LW | Saved-PC slot |
| epc_o | output | XLEN | PC to save |
| eps_we_o | output | 1 | Saved-status write enable |
| eps_o | output | LW+2 | Status to save |
| st_we_o | output | 1 | Status update enable |
| st_o | output | LW+2 | New status word |
| exc_req_o | output | 1 | Level-1 general exception request |
| cause_o | output | CAUSE_W | Exception cause |
| halted_o | output | 1 | Core halted by wait |

## Verification
Directed sequences target one behaviour each:
- all-ones set and clear writes show whether the type filters act per bit;
- a held-high line separates edge latching from level following;
- an enabled line whose level lies beyond the configured count checks that it masks a ready level-1 line below it.

Other directed steps cover the rest:
- a status held constant while an entry stays ready shows the one-cycle gap between strobes;
- a wait with nothing ready, followed by an enable write, places the halted release against the strobe.

Constrained random traffic mixes line toggles, writes, random status words including both mode bits, and occasional waits. It compares every output in every cycle with a bench model, so priority, mode and vector choices are checked in combinations the directed steps do not reach.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;
  typedef enum logic [1:0] {
    ENT_NONE = 2'd0,
    ENT_HIGH = 2'd1,
    ENT_LOW  = 2'd2
  } entry_e;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int N = 8,
  parameter logic [N-1:0] SW_MASK = '0,
  parameter logic [N-1:0] EDGE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_i,
  input  logic         set_we_i,
  input  logic [N-1:0] set_data_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_data_i,
  output logic [N-1:0] pend_o
);
  localparam logic [N-1:0] LVL_MASK = ~(SW_MASK | EDGE_MASK);
  localparam logic [N-1:0] CLR_OK   = SW_MASK | EDGE_MASK;

  logic [N-1:0] irq_q;
  logic [N-1:0] clr_m, set_m, rise, latched, pend_n;

  always_comb begin
    clr_m   = clr_we_i ? (clr_data_i & CLR_OK) : '0;
    set_m   = set_we_i ? (set_data_i & SW_MASK) : '0;
    rise    = irq_i & ~irq_q & EDGE_MASK;
    latched = (pend_o & ~clr_m) | set_m | rise;
    pend_n  = (latched & ~LVL_MASK) | (irq_i & LVL_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= '0;
      pend_o <= '0;
    end else begin
      irq_q  <= irq_i;
      pend_o <= pend_n;
    end
  end
endmodule

// File: rtl/irq_level_sel.sv
module irq_level_sel #(
  parameter int N = 8,
  parameter int LW = 3,
  parameter logic [N*LW-1:0] INT_LEVEL = '0
) (
  input  logic [N-1:0]  active_i,
  output logic [LW-1:0] plev_o
);
  localparam int NLV = 1 << LW;

  logic [NLV-1:1] hit;

  for (genvar lv = 1; lv < NLV; lv++) begin : g_lv
    logic [N-1:0] sel;
    for (genvar b = 0; b < N; b++) begin : g_bit
      assign sel[b] = active_i[b] && (INT_LEVEL[b*LW +: LW] == LW'(lv));
    end
    assign hit[lv] = |sel;
  end

  always_comb begin
    plev_o = '0;
    for (int k = 1; k < NLV; k++) begin
      if (hit[k]) plev_o = LW'(k);
    end
  end
endmodule

// File: rtl/irq_entry_gen.sv
module irq_entry_gen
  import irq_disp_pkg::*;
#(
  parameter int LW = 3,
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] VEC_BASE = 'h1000,
  parameter logic [XLEN-1:0] VEC_STRIDE = 'h40,
  parameter logic [XLEN-1:0] KERN_VEC = 'h300,
  parameter logic [XLEN-1:0] USER_VEC = 'h340,
  parameter logic [XLEN-1:0] DBL_VEC = 'h3c0,
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic            ok_i,
  input  logic [LW-1:0]   plev_i,
  input  logic [LW-1:0]   lvl_i,
  input  logic            excm_i,
  input  logic            um_i,
  output entry_e          kind_o,
  output logic [XLEN-1:0] vector_o,
  output logic [LW-1:0]   epc_idx_o,
  output logic [LW+1:0]   new_st_o
);
  localparam logic [LW-1:0] SLOT_DBL = HAS_DEPC ? LW'(0) : LW'(1);

  always_comb begin
    kind_o    = ENT_NONE;
    vector_o  = VEC_BASE + (XLEN'(plev_i) * VEC_STRIDE);
    epc_idx_o = plev_i;
    new_st_o  = {um_i, 1'b1, plev_i};
    if (ok_i) begin
      if (plev_i > LW'(1)) begin
        kind_o = ENT_HIGH;
      end else begin
        kind_o   = ENT_LOW;
        new_st_o = {um_i, 1'b1, lvl_i};
        if (excm_i) begin
          vector_o  = DBL_VEC;
          epc_idx_o = SLOT_DBL;
        end else begin
          vector_o  = um_i ? USER_VEC : KERN_VEC;
          epc_idx_o = LW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_disp_pkg::*;
#(
  parameter int N = 8,
  parameter int LW = 3,
  parameter int XLEN = 32,
  parameter int CAUSE_W = 8,
  parameter int NUM_LVL = 5,
  parameter int EXCM_LEVEL = 1,
  parameter logic [N*LW-1:0] INT_LEVEL = 24'b011_110_101_100_011_010_001_001,
  parameter logic [N-1:0] SW_MASK = 8'b0000_1001,
  parameter logic [N-1:0] EDGE_MASK = 8'b1001_0010,
  parameter logic [CAUSE_W-1:0] L1_CAUSE = 8'd4,
  parameter logic [XLEN-1:0] VEC_BASE = 'h1000,
  parameter logic [XLEN-1:0] VEC_STRIDE = 'h40,
  parameter logic [XLEN-1:0] KERN_VEC = 'h300,
  parameter logic [XLEN-1:0] USER_VEC = 'h340,
  parameter logic [XLEN-1:0] DBL_VEC = 'h3c0,
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       irq_i,
  input  logic               set_we_i,
  input  logic [N-1:0]       set_data_i,
  input  logic               clr_we_i,
  input  logic [N-1:0]       clr_data_i,
  input  logic               en_we_i,
  input  logic [N-1:0]       en_data_i,
  input  logic [LW+1:0]      status_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               wait_req_i,
  input  logic [LW-1:0]      wait_lvl_i,
  output logic [N-1:0]       pend_o,
  output logic               take_o,
  output logic [XLEN-1:0]    vector_o,
  output logic               epc_we_o,
  output logic [LW-1:0]      epc_idx_o,
  output logic [XLEN-1:0]    epc_o,
  output logic               eps_we_o,
  output logic [LW+1:0]      eps_o,
  output logic               st_we_o,
  output logic [LW+1:0]      st_o,
  output logic               exc_req_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               halted_o
);
  localparam logic [LW-1:0] EXL  = LW'(EXCM_LEVEL);
  localparam logic [LW-1:0] NLVL = LW'(NUM_LVL);

  logic [N-1:0]    en_q;
  logic [LW-1:0]   eff_lvl, cur_lvl, plev;
  logic            excm, um, ok;
  entry_e          kind;
  logic [XLEN-1:0] vec_n;
  logic [LW-1:0]   idx_n;
  logic [LW+1:0]   st_n;

  irq_pend_reg #(.N(N), .SW_MASK(SW_MASK), .EDGE_MASK(EDGE_MASK)) u_pend (
    .clk(clk), .rst(rst), .irq_i(irq_i),
    .set_we_i(set_we_i), .set_data_i(set_data_i),
    .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
    .pend_o(pend_o)
  );

  irq_level_sel #(.N(N), .LW(LW), .INT_LEVEL(INT_LEVEL)) u_sel (
    .active_i(pend_o & en_q), .plev_o(plev)
  );

  always_comb begin
    eff_lvl = wait_req_i ? wait_lvl_i : status_i[LW-1:0];
    excm    = status_i[LW];
    um      = status_i[LW+1];
    cur_lvl = (excm && EXL > eff_lvl) ? EXL : eff_lvl;
    ok      = (plev > cur_lvl) && (plev <= NLVL) && !take_o;
  end

  irq_entry_gen #(
    .LW(LW), .XLEN(XLEN), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE),
    .KERN_VEC(KERN_VEC), .USER_VEC(USER_VEC), .DBL_VEC(DBL_VEC), .HAS_DEPC(HAS_DEPC)
  ) u_ent (
    .ok_i(ok), .plev_i(plev), .lvl_i(eff_lvl), .excm_i(excm), .um_i(um),
    .kind_o(kind), .vector_o(vec_n), .epc_idx_o(idx_n), .new_st_o(st_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      take_o    <= 1'b0;
      vector_o  <= '0;
      epc_we_o  <= 1'b0;
      epc_idx_o <= '0;
      epc_o     <= '0;
      eps_we_o  <= 1'b0;
      eps_o     <= '0;
      st_we_o   <= 1'b0;
      st_o      <= '0;
      exc_req_o <= 1'b0;
      cause_o   <= '0;
      halted_o  <= 1'b0;
    end else begin
      if (en_we_i) en_q <= en_data_i;
      take_o    <= ok;
      epc_we_o  <= ok;
      eps_we_o  <= (kind == ENT_HIGH);
      exc_req_o <= (kind == ENT_LOW);
      st_we_o   <= ok || wait_req_i;
      if (ok) begin
        vector_o  <= vec_n;
        epc_idx_o <= idx_n;
        epc_o     <= pc_i;
        eps_o     <= {um, excm, eff_lvl};
        st_o      <= st_n;
        if (kind == ENT_LOW) cause_o <= L1_CAUSE;
      end else if (wait_req_i) begin
        st_o <= {um, excm, eff_lvl};
      end
      if (ok) halted_o <= 1'b0;
      else if (wait_req_i) halted_o <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int N = 8,
  parameter int LW = 3,
  parameter int CAUSE_W = 8,
  parameter logic [N-1:0] SW_MASK = '0,
  parameter logic [N-1:0] EDGE_MASK = '0,
  parameter logic [CAUSE_W-1:0] L1_CAUSE = '0
) (
  input logic               clk,
  input logic               rst,
  input logic [N-1:0]       irq_i,
  input logic [N-1:0]       pend_o,
  input logic               take_o,
  input logic               epc_we_o,
  input logic [LW-1:0]      epc_idx_o,
  input logic               eps_we_o,
  input logic               st_we_o,
  input logic [LW+1:0]      st_o,
  input logic               exc_req_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic               halted_o
);
  localparam logic [N-1:0] LVM = ~(SW_MASK | EDGE_MASK);

  assert_no_back_to_back_R11: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !take_o);

  assert_halt_release_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(halted_o) |-> take_o);

  assert_high_entry_R7: assert property (@(posedge clk) disable iff (rst)
    (take_o && !exc_req_o) |-> (eps_we_o && epc_we_o && st_we_o && st_o[LW] &&
                                st_o[LW-1:0] == epc_idx_o));

  assert_low_entry_R8: assert property (@(posedge clk) disable iff (rst)
    exc_req_o |-> (take_o && !eps_we_o && cause_o == L1_CAUSE && st_o[LW]));

  assert_level_follow_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_o & LVM) == ($past(irq_i) & LVM)));
endmodule

bind irq_dispatch irq_dispatch_chk #(
  .N(N), .LW(LW), .CAUSE_W(CAUSE_W), .SW_MASK(SW_MASK),
  .EDGE_MASK(EDGE_MASK), .L1_CAUSE(L1_CAUSE)
) u_chk (.*);

// File: tb/irq_dispatch_tb.sv
module irq_dispatch_tb_top;
  localparam int N = 8, LW = 3, XLEN = 32, CW = 8;
  localparam int NUM_LVL = 5, EXL = 1;
  localparam logic [N*LW-1:0] ILV = 24'b011_110_101_100_011_010_001_001;
  localparam logic [N-1:0] SWM = 8'b0000_1001;
  localparam logic [N-1:0] EDM = 8'b1001_0010;
  localparam logic [N-1:0] LVM = ~(SWM | EDM);
  localparam logic [CW-1:0] L1C = 8'd4;
  localparam logic [31:0] VB = 32'h1000, VS = 32'h40;
  localparam logic [31:0] KV = 32'h300, UV = 32'h340, DV = 32'h3c0;

  logic clk = 0, rst = 1;
  logic [N-1:0] irq = 0, set_d = 0, clr_d = 0, en_d = 0;
  logic set_we = 0, clr_we = 0, en_we = 0, wreq = 0;
  logic [LW+1:0] st = 0;
  logic [XLEN-1:0] pc = 0;
  logic [LW-1:0] wlvl = 0;

  logic [N-1:0] pend_o, m_pend = 0, m_en = 0, m_irqq = 0;
  logic take_o, epc_we_o, eps_we_o, st_we_o, exc_req_o, halted_o;
  logic [XLEN-1:0] vector_o, epc_o;
  logic [LW-1:0] epc_idx_o;
  logic [LW+1:0] eps_o, st_o;
  logic [CW-1:0] cause_o;
  logic m_take = 0, m_halt = 0;
  int n_tests = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  irq_dispatch #(
    .N(N), .LW(LW), .XLEN(XLEN), .CAUSE_W(CW), .NUM_LVL(NUM_LVL), .EXCM_LEVEL(EXL),
    .INT_LEVEL(ILV), .SW_MASK(SWM), .EDGE_MASK(EDM), .L1_CAUSE(L1C),
    .VEC_BASE(VB), .VEC_STRIDE(VS), .KERN_VEC(KV), .USER_VEC(UV), .DBL_VEC(DV),
    .HAS_DEPC(1'b1)
  ) dut_i (
    .clk(clk), .rst(rst), .irq_i(irq), .set_we_i(set_we), .set_data_i(set_d),
    .clr_we_i(clr_we), .clr_data_i(clr_d), .en_we_i(en_we), .en_data_i(en_d),
    .status_i(st), .pc_i(pc), .wait_req_i(wreq), .wait_lvl_i(wlvl),
    .pend_o(pend_o), .take_o(take_o), .vector_o(vector_o), .epc_we_o(epc_we_o),
    .epc_idx_o(epc_idx_o), .epc_o(epc_o), .eps_we_o(eps_we_o), .eps_o(eps_o),
    .st_we_o(st_we_o), .st_o(st_o), .exc_req_o(exc_req_o), .cause_o(cause_o),
    .halted_o(halted_o)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int hi_level(logic [N-1:0] act);
    int h = 0;
    for (int b = 0; b < N; b++)
      if (act[b] && int'(ILV[b*LW +: LW]) > h) h = int'(ILV[b*LW +: LW]);
    return h;
  endfunction

  task automatic tick(string tag);
    int lvl, cur, pl;
    logic excm, um, ok;
    logic [XLEN-1:0] e_vec;
    logic [LW-1:0] e_idx;
    logic [LW+1:0] e_st, e_eps;
    logic [N-1:0] nxt;
    lvl  = wreq ? int'(wlvl) : int'(st[LW-1:0]);
    excm = st[LW];
    um   = st[LW+1];
    cur  = (excm && EXL > lvl) ? EXL : lvl;
    pl   = hi_level(m_pend & m_en);
    ok   = (pl > cur) && (pl <= NUM_LVL) && !m_take;
    e_eps = {um, excm, LW'(lvl)};
    if (pl > 1) begin
      e_vec = VB + VS * pl; e_idx = LW'(pl); e_st = {um, 1'b1, LW'(pl)};
    end else begin
      e_st = {um, 1'b1, LW'(lvl)};
      if (excm) begin e_vec = DV; e_idx = 0; end
      else begin e_vec = um ? UV : KV; e_idx = 1; end
    end
    if (ok) m_halt = 0; else if (wreq) m_halt = 1;
    m_take = ok;
    nxt = m_pend;
    if (clr_we) nxt &= ~(clr_d & (SWM | EDM));
    if (set_we) nxt |= set_d & SWM;
    nxt |= irq & ~m_irqq & EDM;
    nxt = (nxt & ~LVM) | (irq & LVM);
    m_pend = nxt;
    if (en_we) m_en = en_d;
    m_irqq = irq;
    @(posedge clk); #2;
    set_we = 0; clr_we = 0; en_we = 0; wreq = 0;
    check({tag, " take"}, 64'(take_o), 64'(ok));
    check({tag, " pend"}, 64'(pend_o), 64'(m_pend));
    check({tag, " halted"}, 64'(halted_o), 64'(m_halt));
    check({tag, " st_we"}, 64'(st_we_o), 64'(ok || (lvl >= 0 && wreq_prev)));
    if (ok) begin
      check({tag, " vector"}, 64'(vector_o), 64'(e_vec));
      check({tag, " epc_idx"}, 64'(epc_idx_o), 64'(e_idx));
      check({tag, " epc"}, 64'(epc_o), 64'(pc));
      check({tag, " st"}, 64'(st_o), 64'(e_st));
      check({tag, " exc_req"}, 64'(exc_req_o), 64'(pl == 1));
      check({tag, " eps_we"}, 64'(eps_we_o), 64'(pl > 1));
      if (pl > 1) check({tag, " eps"}, 64'(eps_o), 64'(e_eps));
      else check({tag, " cause"}, 64'(cause_o), 64'(L1C));
    end else if (wreq_prev) begin
      check({tag, " wait st"}, 64'(st_o), 64'(e_eps));
    end
  endtask

  logic wreq_prev = 0;
  always @(wreq) if (wreq) wreq_prev = 1;

  task automatic step(string tag);
    wreq_prev = wreq;
    tick(tag);
  endtask

  task automatic quiet();
    irq = 0; clr_we = 1; clr_d = '1; en_we = 1; en_d = 0; st = 0;
    step("R12"); step("R12");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_ed01));
    repeat (3) @(posedge clk);
    #2;
    check("R1 pend", 64'(pend_o), 0);
    check("R1 take", 64'(take_o), 0);
    check("R1 halted", 64'(halted_o), 0);
    check("R1 we", 64'({epc_we_o, eps_we_o, st_we_o, exc_req_o}), 0);
    rst = 0;
    @(posedge clk); #2;
    check("R1 after release", 64'({pend_o, take_o, halted_o, st_we_o}), 0);

    set_we = 1; set_d = '1; step("R2");
    clr_we = 1; clr_d = '1; step("R2");
    irq = 8'b0000_0100; step("R3");
    clr_we = 1; clr_d = '1; step("R3");
    irq = 0; step("R3");
    irq = 8'b0000_0010; step("R4");
    step("R4");
    clr_we = 1; clr_d = 8'b0000_0010; step("R4");
    step("R4");
    quiet();
    st = 5'b0_1_000; en_we = 1; en_d = 8'b0000_0001; set_we = 1; set_d = 8'b0000_0001;
    step("R5"); step("R5"); step("R5");
    quiet();
    st = 5'b0_0_001; pc = 32'hcafe_0010; en_we = 1; en_d = 8'b0000_1000;
    set_we = 1; set_d = 8'b0000_1000;
    step("R7"); step("R7"); step("R11"); step("R11");
    quiet();
    st = 5'b1_0_000; pc = 32'h0000_4444; irq = 8'b0100_0000;
    set_we = 1; set_d = 8'b0000_0001; en_we = 1; en_d = 8'b0100_0001;
    step("R6"); step("R6"); irq = 0; step("R6"); step("R8"); step("R8");
    quiet();
    st = 5'b0_0_000; wreq = 1; wlvl = 3'd2; step("R9");
    st = 5'b0_0_010; step("R9");
    set_we = 1; set_d = 8'b0000_1000; step("R10");
    en_we = 1; en_d = 8'b0000_1000; step("R10"); step("R10"); step("R10");
    quiet();

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0) irq = irq ^ N'($urandom);
      if ($urandom_range(0, 9) == 0) begin set_we = 1; set_d = N'($urandom); end
      if ($urandom_range(0, 9) == 0) begin clr_we = 1; clr_d = N'($urandom); end
      if ($urandom_range(0, 19) == 0) begin en_we = 1; en_d = N'($urandom); end
      st = {1'($urandom), ($urandom_range(0, 3) == 0), LW'($urandom_range(0, 3))};
      pc = $urandom;
      if ($urandom_range(0, 19) == 0) begin wreq = 1; wlvl = LW'($urandom_range(0, 4)); end
      step("R12");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule